// File: doc/BRIEF.md
# Power-Good Frequency Strap Latch

This block reads three frequency-select strap pins and holds their value for the clock synthesizer. The strap levels must settle before the active-low power-good input goes low. The first time power-good is seen low for long enough, the block copies the pins into a held code and raises a valid flag. From then on the block is locked: any later activity on the straps or on power-good has no effect. Only a power-on reset clears the lock.

The held code is decoded into a frequency-selection code and a flag that puts all outputs into high impedance. Until the lock is taken, the decoded selection stays at the 100 MHz default. A test-mode input switches off the lock. While it is high, the held code follows the synchronized pins whenever power-good is qualified low, and the valid flag follows that qualification.

Every asynchronous input passes through a synchronizer of its own. A power-good low counts only after it has been seen on consecutive synchronized samples, so a short glitch does not lock the straps.

Top module: `fs_strap_latch`

## Requirements
- R1: While `rst_n` is low, `strap_valid` is 0, `strap_code` is 3'b000, `freq_sel` is 0 and `outputs_hiz` is 0.
- R2: While `strap_valid` is 0, `freq_sel` is 0 (100 MHz default) and `outputs_hiz` is 0, whatever the strap pins hold.
- R3: With default parameters, if `pwrgd_n` falls just after a rising edge and stays low, `strap_valid` is still 0 after the third rising edge and is 1 after the fourth. `strap_code` then holds the pin value {fs_c, fs_b, fs_a} that was presented before power-good fell.
- R4: A low on `pwrgd_n` that lasts a single clock cycle does not set `strap_valid`.
- R5: With `test_mode` low, once `strap_valid` is 1 any change of the strap pins leaves `strap_code` unchanged.
- R6: With `test_mode` low, once `strap_valid` is 1 it stays 1 when `pwrgd_n` returns high and when it goes low again. The later pin values are not captured.
- R7: While `strap_valid` is 1, `freq_sel` decodes the held code {c,b,a} as follows: 001 gives 0 (CPU 100 MHz), 000 gives 1 (CPU 133 MHz), 010 gives 2 (reference/2), 011 gives 3 (reference/8), and 1xx gives 4 (outputs off).
- R8: `outputs_hiz` is 1 exactly when `strap_valid` is 1 and bit 2 of `strap_code` is 1.
- R9: With `test_mode` high, `strap_code` follows the synchronized pins while power-good is qualified low, and `strap_valid` drops to 0 after `pwrgd_n` returns high.
- R10: After a lock, asserting `rst_n` clears `strap_valid`. A fresh qualified low then captures new pin values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fs_a | input | 1 | Frequency strap, bit 0 |
| fs_b | input | 1 | Frequency strap, bit 1 |
| fs_c | input | 1 | Frequency strap, bit 2 |
| pwrgd_n | input | 1 | Active-low power-good, asynchronous |
| test_mode | input | 1 | High bypasses the one-shot lock |
| strap_code | output | 3 | Held strap value {fs_c, fs_b, fs_a} |
| strap_valid | output | 1 | Held code has been captured |
| freq_sel | output | 3 | Decoded frequency selection |
| outputs_hiz | output | 1 | Request to tri-state all clock outputs |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and a two-sample low qualification. These values fix the capture latency at exactly four rising edges after power-good falls, which R3 checks edge by edge. They also make a one-cycle power-good glitch fall just short of qualification, which R4 exercises. With these settings the lock, re-arm, test-mode tracking and all five decode values can each be reached in a few dozen cycles.

// File: rtl/fs_strap_pkg.sv
package fs_strap_pkg;

  localparam int STRAP_W = 3;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    FSEL_CPU100   = 3'd0,
    FSEL_CPU133   = 3'd1,
    FSEL_REF_DIV2 = 3'd2,
    FSEL_REF_DIV8 = 3'd3,
    FSEL_OFF      = 3'd4
  } freq_sel_e;

  // Map a held strap value {c,b,a} to a synthesizer selection.
  function automatic freq_sel_e strap_to_sel(input logic [STRAP_W-1:0] code);
    freq_sel_e r;
    if (code[2]) r = FSEL_OFF;
    else begin
      unique case (code[1:0])
        2'b00:   r = FSEL_CPU133;
        2'b01:   r = FSEL_CPU100;
        2'b10:   r = FSEL_REF_DIV2;
        default: r = FSEL_REF_DIV8;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/fs_sync.sv
// Multi-stage synchronizer with per-bit reset value.
module fs_sync #(
  parameter int              WIDTH     = 1,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VALUE;
        else        stage_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VALUE;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/fs_low_qual.sv
// Declares power-good valid once the synchronized level has been low
// on LOW_QUAL consecutive samples.
module fs_low_qual #(
  parameter int LOW_QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_n,
  output logic qual
);

  localparam int CNT_W = (LOW_QUAL > 1) ? $clog2(LOW_QUAL) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOW_QUAL - 1);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (level_n)       run_q <= '0;
    else if (run_q != CNT_TOP) run_q <= run_q + 1'b1;
  end

  assign qual = !level_n && (run_q == CNT_TOP);

endmodule

// File: rtl/fs_capture.sv
// One-shot capture register with test-mode tracking.
module fs_capture
  import fs_strap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               qual,
  input  logic               test_mode,
  input  logic [STRAP_W-1:0] pins_s,
  output logic [STRAP_W-1:0] code,
  output logic               valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      valid <= 1'b0;
    end else if (test_mode) begin
      valid <= qual;
      if (qual) code <= pins_s;
    end else if (!valid && qual) begin
      code  <= pins_s;
      valid <= 1'b1;
    end
  end

endmodule

// File: rtl/fs_decode.sv
module fs_decode
  import fs_strap_pkg::*;
(
  input  logic               valid,
  input  logic [STRAP_W-1:0] code,
  output logic [SEL_W-1:0]   sel,
  output logic               hiz
);

  freq_sel_e dec;

  always_comb begin
    dec = valid ? strap_to_sel(code) : FSEL_CPU100;
    sel = dec;
    hiz = (dec == FSEL_OFF);
  end

endmodule

// File: rtl/fs_strap_latch.sv
module fs_strap_latch
  import fs_strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_QUAL    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fs_a,
  input  logic               fs_b,
  input  logic               fs_c,
  input  logic               pwrgd_n,
  input  logic               test_mode,
  output logic [STRAP_W-1:0] strap_code,
  output logic               strap_valid,
  output logic [SEL_W-1:0]   freq_sel,
  output logic               outputs_hiz
);

  logic [STRAP_W-1:0] pins_s;
  logic               pg_s;
  logic               pg_qual;

  fs_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES), .RST_VALUE('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .din({fs_c, fs_b, fs_a}), .dout(pins_s)
  );

  fs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VALUE(1'b1)) u_pg_sync (
    .clk(clk), .rst_n(rst_n), .din(pwrgd_n), .dout(pg_s)
  );

  fs_low_qual #(.LOW_QUAL(LOW_QUAL)) u_qual (
    .clk(clk), .rst_n(rst_n), .level_n(pg_s), .qual(pg_qual)
  );

  fs_capture u_cap (
    .clk(clk), .rst_n(rst_n), .qual(pg_qual), .test_mode(test_mode),
    .pins_s(pins_s), .code(strap_code), .valid(strap_valid)
  );

  fs_decode u_dec (
    .valid(strap_valid), .code(strap_code), .sel(freq_sel), .hiz(outputs_hiz)
  );

endmodule

// File: rtl/fs_strap_latch_chk.sv
module fs_strap_latch_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_QUAL    = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwrgd_n,
  input logic       test_mode,
  input logic [2:0] strap_code,
  input logic       strap_valid,
  input logic [2:0] freq_sel,
  input logic       outputs_hiz
);

  p_default_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_valid |-> (freq_sel == 3'd0) && !outputs_hiz);

  p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_valid && !test_mode) |=> $stable(strap_code));

  p_no_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_valid && !test_mode) |=> strap_valid);

  p_sel_133_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_valid && strap_code == 3'b000) |-> freq_sel == 3'd1);

  p_hiz_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outputs_hiz == (strap_valid && strap_code[2]));

  if (SYNC_STAGES == 2 && LOW_QUAL == 2) begin : g_fixed_lat
    p_qualified_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strap_valid) |-> !$past(pwrgd_n, 3) && !$past(pwrgd_n, 4));
  end

endmodule

bind fs_strap_latch fs_strap_latch_chk #(
  .SYNC_STAGES(SYNC_STAGES), .LOW_QUAL(LOW_QUAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .test_mode(test_mode),
  .strap_code(strap_code), .strap_valid(strap_valid),
  .freq_sel(freq_sel), .outputs_hiz(outputs_hiz)
);

// File: tb/test_fs_strap_latch.sv
module test_fs_strap_latch;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       fs_a = 1'b0, fs_b = 1'b0, fs_c = 1'b0;
  logic       pwrgd_n = 1'b1;
  logic       test_mode = 1'b0;
  logic [2:0] strap_code;
  logic       strap_valid;
  logic [2:0] freq_sel;
  logic       outputs_hiz;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [2:0] code;
    logic       valid;
    logic [2:0] sel;
    logic       hiz;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  fs_strap_latch i_fs_strap_latch (
    .clk(clk), .rst_n(rst_n), .fs_a(fs_a), .fs_b(fs_b), .fs_c(fs_c),
    .pwrgd_n(pwrgd_n), .test_mode(test_mode), .strap_code(strap_code),
    .strap_valid(strap_valid), .freq_sel(freq_sel), .outputs_hiz(outputs_hiz)
  );

  // Monitor: compare outputs against the oldest expected item.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (strap_code !== e.code || strap_valid !== e.valid ||
          freq_sel !== e.sel || outputs_hiz !== e.hiz) begin
        n_fails++;
        $display("FAIL %s: actual code=%b valid=%b sel=%0d hiz=%b expected code=%b valid=%b sel=%0d hiz=%b",
                 e.tag, strap_code, strap_valid, freq_sel, outputs_hiz,
                 e.code, e.valid, e.sel, e.hiz);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expect_now(logic [2:0] c, logic v, logic [2:0] s, logic h, string tag);
    exp_t e;
    e.code = c; e.valid = v; e.sel = s; e.hiz = h; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic set_pins(logic [2:0] p);
    @(negedge clk);
    {fs_c, fs_b, fs_a} = p;
  endtask

  task automatic set_pg(logic v);
    @(negedge clk);
    pwrgd_n = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pwrgd_n = 1'b1;
    tick(2);
    expect_now(3'b000, 1'b0, 3'd0, 1'b0, "R1 reset state");
    rst_n = 1'b1;
  endtask

  task automatic lock_with(logic [2:0] p, logic [2:0] s, logic h, string tag);
    do_reset();
    set_pins(p);
    tick(4);
    set_pg(1'b0);
    tick(8);
    expect_now(p, 1'b1, s, h, tag);
  endtask

  initial begin
    // R1: reset state
    #1 rst_n = 1'b0;
    {fs_c, fs_b, fs_a} = 3'b001;
    tick(3);
    expect_now(3'b000, 1'b0, 3'd0, 1'b0, "R1 reset state");
    rst_n = 1'b1;

    // R2: pins alone do nothing before lock
    set_pins(3'b100);
    tick(6);
    expect_now(3'b000, 1'b0, 3'd0, 1'b0, "R2 default before lock");

    // R4: one-cycle glitch on power-good
    set_pg(1'b0);
    set_pg(1'b1);
    tick(6);
    expect_now(3'b000, 1'b0, 3'd0, 1'b0, "R4 glitch ignored");

    // R3: exact capture latency
    set_pins(3'b000);
    tick(4);
    set_pg(1'b0);
    tick(3);
    expect_now(3'b000, 1'b0, 3'd0, 1'b0, "R3 not valid after 3 edges");
    tick(1);
    expect_now(3'b000, 1'b1, 3'd1, 1'b0, "R3 valid after 4 edges, R7 133");

    // R5: pin changes ignored after lock
    set_pins(3'b111);
    tick(6);
    expect_now(3'b000, 1'b1, 3'd1, 1'b0, "R5 code held");

    // R6: no re-arm on power-good toggling
    set_pg(1'b1);
    tick(6);
    expect_now(3'b000, 1'b1, 3'd1, 1'b0, "R6 pg high keeps lock");
    set_pins(3'b011);
    set_pg(1'b0);
    tick(8);
    expect_now(3'b000, 1'b1, 3'd1, 1'b0, "R6 second low not captured");

    // R10: reset clears lock; R7/R8 decode values
    lock_with(3'b100, 3'd4, 1'b1, "R10 relock, R8 hiz code 100");
    lock_with(3'b110, 3'd4, 1'b1, "R8 hiz code 110");
    lock_with(3'b010, 3'd2, 1'b0, "R7 ref/2");
    lock_with(3'b011, 3'd3, 1'b0, "R7 ref/8");
    lock_with(3'b001, 3'd0, 1'b0, "R7 cpu100 locked");

    // R9: test mode tracking
    do_reset();
    @(negedge clk) test_mode = 1'b1;
    set_pins(3'b010);
    tick(4);
    set_pg(1'b0);
    tick(6);
    expect_now(3'b010, 1'b1, 3'd2, 1'b0, "R9 test capture");
    set_pins(3'b110);
    tick(6);
    expect_now(3'b110, 1'b1, 3'd4, 1'b1, "R9 test tracks pins");
    set_pg(1'b1);
    tick(6);
    expect_now(3'b110, 1'b0, 3'd0, 1'b0, "R9 test valid follows pg");
    @(negedge clk) test_mode = 1'b0;

    tick(2);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    tick(20000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual run still busy expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule